// File: doc/BRIEF.md
# Vector Binary64 Data-Class Test

This block takes a vector of two IEEE 754 binary64 elements. It sorts each element into one of twelve data classes: zero, normal, subnormal, infinity, quiet NaN or signalling NaN, each split by sign. It then tests each element's class against a 12-bit class mask carried in a 16-bit operation word. Every lane of the result is set to all ones when its class is selected by the mask and to all zeros when it is not. A two-bit condition code reports whether every tested lane matched, only some did, or none did.

The operation word also carries a single-element flag. When that flag is set, only element 0 is tested. The block is a pure classifier: it never raises or records floating-point exceptions, whatever the operands are (signalling NaNs included). One request is accepted per cycle. Results appear one clock after the request and stay unchanged until the next request.

Top module: `vfp_test_class`

## Requirements
- R1: Each element is classified from its sign bit (bit 63), its exponent (bits 62:52) and its fraction (bits 51:0). Exponent 0 with fraction 0 is a zero. Exponent 0 with a nonzero fraction is subnormal. Exponent all ones with fraction 0 is an infinity. Exponent all ones with fraction bit 51 set is a quiet NaN. Exponent all ones with fraction bit 51 clear and a nonzero fraction is a signalling NaN. Every other element is normal.
- R2: The class mask is `op_data[15:4]`. From bit 11 down, the bits select +zero, -zero, +normal, -normal, +subnormal, -subnormal, +infinity, -infinity, +quiet NaN, -quiet NaN, +signalling NaN and -signalling NaN. A lane whose class bit is set in the mask returns all ones; any other lane returns zero. Lane i occupies `src[64*i +: 64]` and `result[64*i +: 64]`. `op_data[2:0]` has no effect.
- R3: When every tested lane matches, `cc` is 0.
- R4: When both lanes are tested and exactly one of them matches, `cc` is 1.
- R5: When no tested lane matches, `cc` is 3. The value 2 is never produced.
- R6: When `op_data[3]` is 1, only element 0 is tested. `cc` is 0 if element 0 matches and 3 if it does not. Lane 1 of `result` is zero whatever element 1 holds.
- R7: `out_valid` rises in the cycle after an accepted `in_valid`, with `result` and `cc` valid in that same cycle.
- R8: While `in_valid` is low, `result` and `cc` keep their last values and `out_valid` is low.
- R9: While reset is asserted (`rst_n` low), `out_valid`, `result` and `cc` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| src | input | 128 | Two binary64 elements, element 0 in the low half |
| op_data | input | 16 | Class mask in [15:4], single-element flag in [3] |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | Per-lane all-ones or zero match mask |
| cc | output | 2 | 0 all tested lanes match, 1 some match, 3 none |

## Verification
The bench goes after the edges between classes. These are the smallest normal against the largest subnormal, and a quiet NaN whose only fraction bit is the top one against a signalling NaN whose only fraction bit is the lowest. A classifier that tested the wrong fraction bit or compared the exponent off by one would light the neighbouring mask bit and turn an all-ones lane into zero. Each of the twelve classes is also swept with a mask that selects only that class's sign twin, which catches swapped sign halves. In single-element mode, element 1 is given a matching value. A design that still counted lane 1 would report a code of 1 or 0 where 3 is expected, or leave lane 1 nonzero.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int unsigned CLASS_N = 12;
  typedef logic [CLASS_N-1:0] class_vec_t;

  // Pair index: each kind owns bits {2k+1 (positive), 2k (negative)}
  typedef enum logic [2:0] {
    K_SNAN = 3'd0,
    K_QNAN = 3'd1,
    K_INF  = 3'd2,
    K_SUB  = 3'd3,
    K_NORM = 3'd4,
    K_ZERO = 3'd5
  } kind_e;

  function automatic class_vec_t kind_to_onehot(input kind_e k, input logic neg);
    class_vec_t v;
    v = '0;
    v[{k, ~neg}] = 1'b1;
    return v;
  endfunction

  // Condition code from the number of hits among the tested lanes
  function automatic logic [1:0] summarize(input int unsigned hits, input int unsigned tested);
    if (hits == tested) return 2'd0;
    else if (hits != 0) return 2'd1;
    else return 2'd3;
  endfunction
endpackage

// File: rtl/tdc_lane_classify.sv
module tdc_lane_classify
  import tdc_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52,
  localparam int unsigned ELEM_W = 1 + EXP_W + FRAC_W
) (
  input  logic [ELEM_W-1:0] elem,
  output class_vec_t        cls
);
  function automatic kind_e decode_kind(input logic [EXP_W-1:0] e, input logic [FRAC_W-1:0] f);
    if (e == '0) return (f == '0) ? K_ZERO : K_SUB;
    if (e == '1) begin
      if (f == '0) return K_INF;
      return f[FRAC_W-1] ? K_QNAN : K_SNAN;
    end
    return K_NORM;
  endfunction

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  kind_e             kind;

  assign {sign, expo, frac} = elem;
  assign kind = decode_kind(expo, frac);
  assign cls  = kind_to_onehot(kind, sign);
endmodule

// File: rtl/tdc_lane_match.sv
module tdc_lane_match
  import tdc_pkg::*;
#(
  parameter int unsigned ELEM_W = 64
) (
  input  class_vec_t        cls,
  input  class_vec_t        mask,
  input  logic              enable,
  output logic              hit,
  output logic [ELEM_W-1:0] fill
);
  assign hit  = enable && ((cls & mask) != '0);
  assign fill = {ELEM_W{hit}};
endmodule

// File: rtl/tdc_cc_summary.sv
module tdc_cc_summary
  import tdc_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic [LANES-1:0] hits,
  input  logic             single,
  output logic [1:0]       cc
);
  int unsigned hit_cnt;
  int unsigned tested;

  always_comb begin
    hit_cnt = 0;
    for (int i = 0; i < LANES; i++) hit_cnt += 32'(hits[i]);
    tested = single ? 1 : LANES;
    cc = summarize(hit_cnt, tested);
  end
endmodule

// File: rtl/vfp_test_class.sv
module vfp_test_class
  import tdc_pkg::*;
#(
  parameter int unsigned LANES      = 2,
  parameter int unsigned EXP_W      = 11,
  parameter int unsigned FRAC_W     = 52,
  parameter int unsigned OP_W       = 16,
  parameter int unsigned MASK_LSB   = 4,
  parameter int unsigned SINGLE_BIT = 3,
  localparam int unsigned ELEM_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned VEC_W  = LANES * ELEM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src,
  input  logic [OP_W-1:0]  op_data,
  output logic             out_valid,
  output logic [VEC_W-1:0] result,
  output logic [1:0]       cc
);
  class_vec_t       class_mask;
  logic             single;
  class_vec_t       lane_cls [LANES];
  logic [LANES-1:0] lane_hit;
  logic [VEC_W-1:0] fill_d;
  logic [1:0]       cc_d;

  assign class_mask = op_data[MASK_LSB +: CLASS_N];
  assign single     = op_data[SINGLE_BIT];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic en;
    assign en = (g == 0) || !single;

    tdc_lane_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .elem (src[g*ELEM_W +: ELEM_W]),
      .cls  (lane_cls[g])
    );

    tdc_lane_match #(.ELEM_W(ELEM_W)) u_match (
      .cls    (lane_cls[g]),
      .mask   (class_mask),
      .enable (en),
      .hit    (lane_hit[g]),
      .fill   (fill_d[g*ELEM_W +: ELEM_W])
    );

    // R1
    cls_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot(lane_cls[g]));

    if (g > 0) begin : g_single
      // R6
      single_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && single) |=> (result[g*ELEM_W +: ELEM_W] == '0));
    end
  end

  tdc_cc_summary #(.LANES(LANES)) u_cc (
    .hits   (lane_hit),
    .single (single),
    .cc     (cc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= 2'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= fill_d;
        cc     <= cc_d;
      end
    end
  end

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(cc)));

  // R3
  cc_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cc == 2'd0) |-> (result[ELEM_W-1:0] == '1));

  // R5
  cc_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cc == 2'd3) |-> (result == '0));

  // R5
  cc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cc != 2'd2));
endmodule

// File: tb/test_vfp_test_class.sv
module test_vfp_test_class;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src = '0;
  logic [15:0]  op_data = '0;
  logic         out_valid;
  logic [127:0] result;
  logic [1:0]   cc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfp_test_class i_vfp_test_class (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .op_data(op_data), .out_valid(out_valid), .result(result), .cc(cc)
  );

  // Build a sample element for mask bit b (11 = +zero ... 0 = -signalling NaN)
  function automatic logic [63:0] sample(input int b);
    logic s;
    logic [10:0] e;
    logic [51:0] f;
    s = (b % 2 == 0);
    case (b / 2)
      5: begin e = 11'd0;     f = 52'd0; end
      4: begin e = 11'h3ff;   f = 52'h123; end
      3: begin e = 11'd0;     f = 52'd1; end
      2: begin e = 11'h7ff;   f = 52'd0; end
      1: begin e = 11'h7ff;   f = (52'd1 << 51) | 52'd5; end
      default: begin e = 11'h7ff; f = 52'd1; end
    endcase
    return {s, e, f};
  endfunction

  function automatic logic [15:0] opw(input int b, input logic single);
    return (16'd1 << (b + 4)) | {12'd0, single, 3'b101};
  endfunction

  task automatic check(input string req, input logic [127:0] exp_r, input logic [1:0] exp_cc, input logic exp_v);
    checks++;
    if (result !== exp_r || cc !== exp_cc || out_valid !== exp_v) begin
      fails++;
      $display("FAIL %s: result=%h cc=%0d v=%0b expected result=%h cc=%0d v=%0b",
               req, result, cc, out_valid, exp_r, exp_cc, exp_v);
    end
  endtask

  task automatic issue(input logic [63:0] e1, input logic [63:0] e0, input logic [15:0] op);
    @(negedge clk);
    src = {e1, e0}; op_data = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  localparam logic [63:0] ONES = '1;

  task automatic t_reset();
    // R9
    check("R9 reset", '0, 2'd0, 1'b0);
  endtask

  task automatic t_sweep();
    // R1 R2 R3: each class alone hits its own bit; its sign twin misses (R5)
    for (int b = 0; b < 12; b++) begin
      issue(sample(b), sample(b), opw(b, 1'b0));
      check($sformatf("R1 R3 class bit %0d", b), {ONES, ONES}, 2'd0, 1'b1);
      issue(sample(b), sample(b), opw(b ^ 1, 1'b0));
      check($sformatf("R2 R5 twin of bit %0d", b), '0, 2'd3, 1'b1);
    end
  endtask

  task automatic t_partial();
    // R4: lane 0 +inf matches, lane 1 -normal does not
    issue(sample(8), sample(5), opw(5, 1'b0));
    check("R4 lane0 only", {64'd0, ONES}, 2'd1, 1'b1);
    // R4: lane 1 matches only
    issue(sample(8), sample(5), opw(8, 1'b0));
    check("R4 lane1 only", {ONES, 64'd0}, 2'd1, 1'b1);
  endtask

  task automatic t_boundary();
    // R1: smallest normal vs largest subnormal
    issue(64'h000F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, opw(9, 1'b0));
    check("R1 min normal", {64'd0, ONES}, 2'd1, 1'b1);
    issue(64'h000F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000, opw(7, 1'b0));
    check("R1 max subnormal", {ONES, 64'd0}, 2'd1, 1'b1);
    // R1: quiet NaN with only top fraction bit; signalling NaN with only bit 0
    issue(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, opw(3, 1'b0));
    check("R1 quiet NaN edge", {64'd0, ONES}, 2'd1, 1'b1);
    issue(64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0000, opw(1, 1'b0));
    check("R1 signalling NaN edge", {ONES, 64'd0}, 2'd1, 1'b1);
    // R1: largest finite is normal, not infinity
    issue(64'h7FEF_FFFF_FFFF_FFFF, 64'h7FEF_FFFF_FFFF_FFFF, opw(9, 1'b0));
    check("R1 max finite", {ONES, ONES}, 2'd0, 1'b1);
  endtask

  task automatic t_single();
    // R6: lane 1 matches but is ignored; lane 0 misses
    issue(sample(11), sample(9), opw(11, 1'b1));
    check("R6 single miss", '0, 2'd3, 1'b1);
    // R6: lane 0 matches, lane 1 zeroed
    issue(sample(11), sample(11), opw(11, 1'b1));
    check("R6 single hit", {64'd0, ONES}, 2'd0, 1'b1);
  endtask

  task automatic t_mixed_mask();
    // R2: full mask, low bits of op_data ignored
    issue(sample(0), sample(6), 16'hFFF7);
    check("R2 full mask", {ONES, ONES}, 2'd0, 1'b1);
  endtask

  task automatic t_hold();
    // R7 R8: result holds with valid low
    issue(sample(4), sample(2), opw(4, 1'b0));
    check("R7 latency", {ONES, 64'd0}, 2'd1, 1'b1);
    @(negedge clk);
    src = {sample(2), sample(2)}; op_data = opw(2, 1'b0);
    @(negedge clk);
    check("R8 hold", {ONES, 64'd0}, 2'd1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_sweep();
    t_partial();
    t_boundary();
    t_single();
    t_mixed_mask();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run=hung expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule